// File: doc/BRIEF.md
# Half-Bridge Pulse Command Encoder

This block sits between ground-referenced control logic and one leg of a half bridge. It takes two command inputs. The low-side command drives a local gate enable directly. The high-side command is never sent as a level. Each change of that command becomes a short burst of fixed-width pulses on one of two single-ended channels. Together the two channels form a differential link to a remote high-side driver. A change that asks for turn-on sends two pulses on the "on" channel. A change that asks for turn-off sends one pulse on the "off" channel.

A set/reset conduction latch records whether the high side is believed to be on. The block refuses any command pair that would put both switches in conduction at once. A refused request stays pending and is served once the conflicting switch has turned off. The low-side turn-on is delayed by a parameterised number of cycles. This covers the off-burst and the remote path, so the two switches cannot overlap at either transition.

The supply-OK input gates every output directly. A synchronous reset clears all state. Both command inputs pass through a synchronizer before they are used.

Top module: `hb_pulse_encoder`

## Requirements
- R1: The high-side command `hs_cmd_n` is active-low. When it falls, `hs_on_pulse` emits two pulses, each PULSE_W cycles high, with GAP_W low cycles between them. With SYNC_STAGES synchronizer flops, the first pulse is high starting SYNC_STAGES+1 clock edges after the input changes.
- R2: When `hs_cmd_n` rises while the high side is believed on, `hs_off_pulse` emits exactly one pulse of PULSE_W cycles.
- R3: `hs_on_pulse` and `hs_off_pulse` are never high in the same cycle.
- R4: The high side counts as on from the edge that starts its turn-on burst until the edge that starts its turn-off burst. During that time a low-side request (`ls_cmd` high, active-high) is refused and `ls_gate` stays 0.
- R5: A high-side turn-on is refused while the synchronized low-side request is high or the low-side delay counter is nonzero. If both switches are requested in the same cycle from the all-off state, the low side wins.
- R6: `ls_gate` rises LS_DELAY+SYNC_STAGES clock edges after `ls_cmd` rises. It falls SYNC_STAGES+1 clock edges after `ls_cmd` falls.
- R7: A burst in progress is never cut short by a change of `hs_cmd_n`. If the requested high-side state differs from the latched state when a burst ends, the matching burst starts one cycle later.
- R8: A refused command produces no pulses and no gate. It is re-evaluated every cycle and acted on once the conflicting switch is off.
- R9: While `supply_ok` is 0, `ls_gate`, `hs_on_pulse` and `hs_off_pulse` are 0 in the same cycle. Any burst is abandoned and the high side is taken as off. After `supply_ok` returns, a pending high-side on request is sent again as a new two-pulse burst.
- R10: While `rst` is high, all outputs are 0. After reset the high side is taken as off, so releasing reset with the high-side command inactive sends no turn-off pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| supply_ok | input | 1 | Supply above threshold; 0 forces all outputs off |
| hs_cmd_n | input | 1 | High-side command, active low, asynchronous |
| ls_cmd | input | 1 | Low-side command, active high, asynchronous |
| ls_gate | output | 1 | Low-side gate enable |
| hs_on_pulse | output | 1 | Turn-on channel to the remote high-side driver |
| hs_off_pulse | output | 1 | Turn-off channel to the remote high-side driver |

## Verification
The stimulus table steps the leg through a fixed sequence of command pairs:
- plain high-side on and off;
- a low-side request while the high side is on;
- swapping both commands in one step;
- a high-side request held against an active low side and then released;
- both requested at once from the all-off state;
- a supply drop with the high-side request held.
Each step has its expected pulse count per channel and final gate level, so the steps separate refusal, priority, re-evaluation and supply gating. Directed traces then check, cycle by cycle, the position and width of each pulse in a turn-on burst that is interrupted by a turn-off request. This distinguishes queuing from truncation. Further directed checks time the low-side delay edge by edge, and cover supply loss in mid-burst and a reset while the high side is on.

// File: rtl/hbpe_pkg.sv
package hbpe_pkg;

   typedef enum logic [2:0] {
      B_IDLE = 3'd0,
      B_ON1  = 3'd1,
      B_GAP  = 3'd2,
      B_ON2  = 3'd3,
      B_OFF  = 3'd4
   } burst_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hbpe_sync.sv
module hbpe_sync #(
   parameter int unsigned WIDTH   = 2,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("hbpe_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stg_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stg_q[s] <= RST_VAL;
               else     stg_q[s] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stg_q[s] <= RST_VAL;
               else     stg_q[s] <= stg_q[s-1];
            end
         end
      end
   endgenerate

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/hbpe_burst.sv
module hbpe_burst
   import hbpe_pkg::*;
#(
   parameter int unsigned PULSE_W = 4,
   parameter int unsigned GAP_W   = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic abort,
   input  logic go_on,
   input  logic go_off,
   output logic busy,
   output logic on_raw,
   output logic off_raw
);

   localparam int unsigned SPAN = max2(PULSE_W, GAP_W);
   localparam int unsigned CW   = $clog2(SPAN + 1);
   localparam logic [CW-1:0] PW_LAST  = CW'(PULSE_W - 1);
   localparam logic [CW-1:0] GAP_LAST = CW'(GAP_W - 1);

   generate
      if (PULSE_W < 1) begin : g_bad_pw
         $error("hbpe_burst: PULSE_W must be at least 1");
      end
      if (GAP_W < 1) begin : g_bad_gap
         $error("hbpe_burst: GAP_W must be at least 1");
      end
   endgenerate

   burst_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q + CW'(1);
      unique case (state_q)
         B_IDLE: begin
            cnt_d = '0;
            if (go_on)       state_d = B_ON1;
            else if (go_off) state_d = B_OFF;
         end
         B_ON1: if (cnt_q == PW_LAST) begin
            state_d = B_GAP;
            cnt_d   = '0;
         end
         B_GAP: if (cnt_q == GAP_LAST) begin
            state_d = B_ON2;
            cnt_d   = '0;
         end
         B_ON2: if (cnt_q == PW_LAST) begin
            state_d = B_IDLE;
            cnt_d   = '0;
         end
         B_OFF: if (cnt_q == PW_LAST) begin
            state_d = B_IDLE;
            cnt_d   = '0;
         end
         default: begin
            state_d = B_IDLE;
            cnt_d   = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst || abort) begin
         state_q <= B_IDLE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign busy    = (state_q != B_IDLE);
   assign on_raw  = (state_q == B_ON1) || (state_q == B_ON2);
   assign off_raw = (state_q == B_OFF);

   // Width monitor: consecutive high cycles seen on either channel so far.
   localparam int unsigned RW = $clog2(PULSE_W + 1) + 1;
   logic [RW-1:0] on_run_q, off_run_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         on_run_q  <= '0;
         off_run_q <= '0;
      end else begin
         on_run_q  <= on_raw  ? on_run_q  + RW'(1) : '0;
         off_run_q <= off_raw ? off_run_q + RW'(1) : '0;
      end
   end

   // R1, R2: no pulse stays high longer than PULSE_W cycles
   p_width_on_r1: assert property (@(posedge clk) disable iff (rst)
      on_raw |-> (on_run_q < RW'(PULSE_W)));
   p_width_off_r2: assert property (@(posedge clk) disable iff (rst)
      off_raw |-> (off_run_q < RW'(PULSE_W)));

   // R7: once the gap has run out, the second pulse follows unless aborted
   p_second_pulse_r7: assert property (@(posedge clk) disable iff (rst || abort)
      (state_q == B_GAP && cnt_q == GAP_LAST) |=> on_raw);

   // R7: a start request is only taken from idle
   p_start_idle_r7: assert property (@(posedge clk) disable iff (rst || abort)
      (busy && !on_raw && !off_raw) |=> (busy || !$past(state_q == B_GAP)));

endmodule

// File: rtl/hbpe_ls_delay.sv
module hbpe_ls_delay #(
   parameter int unsigned DELAY = 12
) (
   input  logic clk,
   input  logic rst,
   input  logic clr,
   input  logic allow,
   output logic gate,
   output logic engaged
);

   localparam int unsigned DW = $clog2(DELAY + 1);
   localparam logic [DW-1:0] D_TOP = DW'(DELAY);

   generate
      if (DELAY < 1) begin : g_bad_delay
         $error("hbpe_ls_delay: DELAY must be at least 1");
      end
   endgenerate

   logic [DW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst || clr || !allow) cnt_q <= '0;
      else if (cnt_q != D_TOP)  cnt_q <= cnt_q + DW'(1);
   end

   assign gate    = (cnt_q == D_TOP);
   assign engaged = (cnt_q != '0);

   // R6: the gate only comes on after the permission was present
   p_gate_after_allow_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(gate) |-> $past(allow));

endmodule

// File: rtl/hb_pulse_encoder.sv
module hb_pulse_encoder #(
   parameter int unsigned PULSE_W     = 4,
   parameter int unsigned GAP_W       = 4,
   parameter int unsigned REMOTE_LAT  = 4,
   parameter int unsigned LS_DELAY    = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic supply_ok,
   input  logic hs_cmd_n,
   input  logic ls_cmd,
   output logic ls_gate,
   output logic hs_on_pulse,
   output logic hs_off_pulse
);

   localparam int unsigned DELAY_MIN = PULSE_W + REMOTE_LAT;

   generate
      if (LS_DELAY < DELAY_MIN) begin : g_bad_delay
         $error("hb_pulse_encoder: LS_DELAY must cover the off burst and remote latency");
      end
   endgenerate

   // bit 0: high-side command (idle high), bit 1: low-side command (idle low)
   logic [1:0] sync_q;

   hbpe_sync #(
      .WIDTH   (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({ls_cmd, hs_cmd_n}),
      .q   (sync_q)
   );

   logic hs_req, ls_req;
   assign hs_req = ~sync_q[0];
   assign ls_req =  sync_q[1];

   logic abort;
   assign abort = ~supply_ok;

   logic hs_on_q;
   logic busy, on_raw, off_raw;
   logic gate_raw, ls_engaged;
   logic go_on, go_off, ls_allow;

   assign go_on  = ~busy & supply_ok & hs_req & ~hs_on_q & ~ls_req & ~ls_engaged;
   assign go_off = ~busy & supply_ok & ~hs_req & hs_on_q;
   assign ls_allow = ls_req & ~hs_on_q & supply_ok;

   // conduction latch: set by a turn-on burst, cleared by turn-off or supply loss
   always_ff @(posedge clk) begin
      if (rst || abort) hs_on_q <= 1'b0;
      else if (go_on)   hs_on_q <= 1'b1;
      else if (go_off)  hs_on_q <= 1'b0;
   end

   hbpe_burst #(
      .PULSE_W (PULSE_W),
      .GAP_W   (GAP_W)
   ) u_burst (
      .clk     (clk),
      .rst     (rst),
      .abort   (abort),
      .go_on   (go_on),
      .go_off  (go_off),
      .busy    (busy),
      .on_raw  (on_raw),
      .off_raw (off_raw)
   );

   hbpe_ls_delay #(
      .DELAY (LS_DELAY)
   ) u_dly (
      .clk     (clk),
      .rst     (rst),
      .clr     (abort),
      .allow   (ls_allow),
      .gate    (gate_raw),
      .engaged (ls_engaged)
   );

   assign ls_gate      = gate_raw & supply_ok & ~rst;
   assign hs_on_pulse  = on_raw   & supply_ok & ~rst;
   assign hs_off_pulse = off_raw  & supply_ok & ~rst;

   // R3: the two channels are mutually exclusive
   p_excl_r3: assert property (@(posedge clk) disable iff (rst)
      !(hs_on_pulse && hs_off_pulse));

   // R4: low-side gate never on while the high side is believed on
   p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
      ls_gate |-> !hs_on_q);

   // R2: a turn-off burst only follows a believed-on high side
   p_off_after_on_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(hs_off_pulse) |-> $past(hs_on_q));

   // R9: supply loss clears the conduction latch
   p_uv_clear_r9: assert property (@(posedge clk) disable iff (rst)
      !supply_ok |=> !hs_on_q);

endmodule

// File: tb/sim_hb_pulse_encoder.sv
module sim_hb_pulse_encoder;

   localparam int W = 4;
   localparam int G = 4;
   localparam int D = 12;
   localparam int S = 2;

   logic clk = 1'b0;
   logic rst, supply_ok, hs_cmd_n, ls_cmd;
   logic ls_gate, hs_on_pulse, hs_off_pulse;

   always #4 clk = ~clk;

   hb_pulse_encoder #(
      .PULSE_W (W), .GAP_W (G), .REMOTE_LAT (4), .LS_DELAY (D), .SYNC_STAGES (S)
   ) u0 (
      .clk (clk), .rst (rst), .supply_ok (supply_ok),
      .hs_cmd_n (hs_cmd_n), .ls_cmd (ls_cmd),
      .ls_gate (ls_gate), .hs_on_pulse (hs_on_pulse), .hs_off_pulse (hs_off_pulse)
   );

   int n_chk = 0, n_fail = 0, n_overlap = 0;
   int on_rises = 0, off_rises = 0;
   logic prev_on = 1'b0, prev_off = 1'b0;
   bit finished = 0;

   task automatic chk(input bit good, input string tag, input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // wait for the next falling edge and observe outputs there
   task automatic tick();
      @(negedge clk);
      if (hs_on_pulse && hs_off_pulse) n_overlap++;
      if (hs_on_pulse && !prev_on)   on_rises++;
      if (hs_off_pulse && !prev_off) off_rises++;
      prev_on  = hs_on_pulse;
      prev_off = hs_off_pulse;
   endtask

   typedef struct packed {
      logic       hs_n;
      logic       ls;
      logic       ok;
      logic [7:0] cyc;
      logic [3:0] n_on;
      logic [3:0] n_off;
      logic       gate;
      logic [3:0] req;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 1'b0, 1'b1, 8'd30, 4'd0, 4'd0, 1'b0, 4'd10}, // R10 idle after reset
      '{1'b0, 1'b0, 1'b1, 8'd30, 4'd2, 4'd0, 1'b0, 4'd1},  // R1 turn-on burst
      '{1'b0, 1'b1, 1'b1, 8'd40, 4'd0, 4'd0, 1'b0, 4'd4},  // R4 low side refused
      '{1'b1, 1'b1, 1'b1, 8'd40, 4'd0, 4'd1, 1'b1, 4'd2},  // R2 off burst, then low side
      '{1'b0, 1'b1, 1'b1, 8'd30, 4'd0, 4'd0, 1'b1, 4'd5},  // R5 high side refused
      '{1'b0, 1'b0, 1'b1, 8'd40, 4'd2, 4'd0, 1'b0, 4'd8},  // R8 pending request served
      '{1'b0, 1'b0, 1'b0, 8'd20, 4'd0, 4'd0, 1'b0, 4'd9},  // R9 supply low
      '{1'b0, 1'b0, 1'b1, 8'd40, 4'd2, 4'd0, 1'b0, 4'd9},  // R9 re-sent after recovery
      '{1'b1, 1'b0, 1'b1, 8'd30, 4'd0, 4'd1, 1'b0, 4'd2},  // R2 turn-off
      '{1'b0, 1'b1, 1'b1, 8'd40, 4'd0, 4'd0, 1'b1, 4'd5},  // R5 both at once, low wins
      '{1'b1, 1'b0, 1'b1, 8'd20, 4'd0, 4'd0, 1'b0, 4'd6}   // R6 gate released
   };

   initial begin
      #(8 * 100000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      string tag;
      int first;
      bit ok_tr;
      // ---- R10: outputs held off during reset, even with both commands active
      rst = 1'b1; supply_ok = 1'b1; hs_cmd_n = 1'b0; ls_cmd = 1'b1;
      repeat (4) tick();
      chk({ls_gate, hs_on_pulse, hs_off_pulse} == 3'b000, "R10 outputs in reset",
          int'({ls_gate, hs_on_pulse, hs_off_pulse}), 0);
      hs_cmd_n = 1'b1; ls_cmd = 1'b0;
      repeat (3) tick();
      rst = 1'b0;
      on_rises = 0; off_rises = 0;

      // ---- stimulus table
      for (int i = 0; i < NV; i++) begin
         hs_cmd_n  = VECS[i].hs_n;
         ls_cmd    = VECS[i].ls;
         supply_ok = VECS[i].ok;
         on_rises  = 0;
         off_rises = 0;
         for (int c = 0; c < int'(VECS[i].cyc); c++) tick();
         tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
         chk(on_rises == int'(VECS[i].n_on), {tag, " on pulses"}, on_rises, int'(VECS[i].n_on));
         chk(off_rises == int'(VECS[i].n_off), {tag, " off pulses"}, off_rises, int'(VECS[i].n_off));
         chk(ls_gate == VECS[i].gate, {tag, " gate"}, int'(ls_gate), int'(VECS[i].gate));
      end

      // ---- R1 / R7: exact trace of a turn-on burst interrupted by a turn-off request
      begin
         logic on_tr [33];
         logic off_tr [33];
         hs_cmd_n = 1'b0;
         for (int k = 1; k <= 32; k++) begin
            tick();
            on_tr[k]  = hs_on_pulse;
            off_tr[k] = hs_off_pulse;
            if (k == 5) hs_cmd_n = 1'b1;
         end
         ok_tr = 1; first = 0;
         for (int k = 1; k <= 32; k++) begin
            logic e;
            e = ((k >= S+1) && (k <= S+W)) || ((k >= S+1+W+G) && (k <= S+2*W+G));
            if (on_tr[k] !== e && ok_tr) begin ok_tr = 0; first = k; end
         end
         chk(ok_tr, "R1 on-channel trace first mismatch", first, 0);
         ok_tr = 1; first = 0;
         for (int k = 1; k <= 32; k++) begin
            logic e;
            e = (k >= S+2*W+G+2) && (k <= S+3*W+G+1);
            if (off_tr[k] !== e && ok_tr) begin ok_tr = 0; first = k; end
         end
         chk(ok_tr, "R7 queued off pulse after full burst, first mismatch", first, 0);
      end

      // ---- R6: low-side delay measured edge by edge
      repeat (5) tick();
      ls_cmd = 1'b1;
      first = 0;
      for (int k = 1; k <= 40; k++) begin
         tick();
         if (ls_gate && first == 0) first = k;
      end
      chk(first == D + S, "R6 gate rise edges", first, D + S);
      ls_cmd = 1'b0;
      first = 0;
      for (int k = 1; k <= 10; k++) begin
         tick();
         if (!ls_gate && first == 0) first = k;
      end
      chk(first == S + 1, "R6 gate fall edges", first, S + 1);

      // ---- R9: supply loss with the gate on forces it off in the same cycle
      ls_cmd = 1'b1;
      repeat (20) tick();
      supply_ok = 1'b0;
      #1;
      chk(ls_gate == 1'b0, "R9 gate forced off", int'(ls_gate), 0);
      repeat (5) tick();
      ls_cmd = 1'b0;
      supply_ok = 1'b1;
      repeat (10) tick();

      // ---- R9: supply loss during a burst, then re-sent
      hs_cmd_n = 1'b0;
      repeat (S + 2) tick();
      supply_ok = 1'b0;
      #1;
      chk(hs_on_pulse == 1'b0, "R9 pulse forced off mid-burst", int'(hs_on_pulse), 0);
      on_rises = 0;
      repeat (10) tick();
      chk(on_rises == 0, "R9 no pulses while supply low", on_rises, 0);
      supply_ok = 1'b1;
      repeat (30) tick();
      chk(on_rises == 2, "R9 burst re-sent after recovery", on_rises, 2);

      // ---- R10: reset while on; high side taken as off afterwards
      hs_cmd_n = 1'b1;
      rst = 1'b1;
      repeat (3) tick();
      rst = 1'b0;
      off_rises = 0;
      repeat (30) tick();
      chk(off_rises == 0, "R10 no off pulse after reset", off_rises, 0);

      // ---- R3: channel exclusivity over the whole run
      chk(n_overlap == 0, "R3 overlapping channel cycles", n_overlap, 0);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule